// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a shift register of `WIDTH` stages (eight by default) that takes a whole word at once and then releases it one bit per clock at a single output pin. Pulling the active-low load input low copies the parallel word into every stage straight away, with no clock edge needed. While load stays low, the output pin follows the most significant parallel bit level-wise. Once load is released, each rising clock edge moves every stage one place toward the most significant end and takes the serial input into the least significant stage.

The internal stages are not visible. Only the last stage comes out, together with its complement. A clock-inhibit input freezes the contents while it is high, so a shared clock can run on without losing the word. A synchronous active-low reset clears all stages. An active load wins over both the reset and the inhibit.

A typical use is to read a parallel word such as a set of switches or flags and send it over one wire. Assert load, release it, then give `WIDTH` clock edges. The most significant bit appears first, the least significant bit appears last, and the serial-input bits follow behind.

Top module: `piso_shifter`

## Requirements
- R1: The register has `WIDTH` stages (default 8). Only the last stage, bit `WIDTH-1`, is visible, on `ser_out`.
- R2: While `load_n` is 0, every stage takes `par_in` without a clock edge, and `ser_out` equals `par_in[WIDTH-1]` and follows changes of it at once.
- R3: While `load_n` is 0, rising clock edges cause no shift; the stages still equal `par_in`.
- R4: With `load_n` = 1, `rst_n` = 1 and `hold_clk` = 0, each rising edge moves stage i to stage i+1 and puts `ser_in` into stage 0.
- R5: After a load of word P is released, `ser_out` shows P[7] before any edge. After k edges with 1 <= k <= 7 it shows P[7-k]. After edge 8+j it shows the `ser_in` bit taken at shift j+1.
- R6: While `hold_clk` is 1 and `load_n` is 1, rising edges leave all stages unchanged, and `ser_in` is not taken.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: With `load_n` = 1, a rising edge while `rst_n` is 0 clears every stage to 0. With `load_n` = 0, the load wins over the reset.
- R9: A load works while `hold_clk` is 1. The inhibit only suppresses shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifts on the rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all stages |
| load_n | input | 1 | Active-low asynchronous parallel load |
| hold_clk | input | 1 | Clock inhibit; high freezes the stages |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 leaves first |
| ser_out | output | 1 | Last stage |
| ser_out_n | output | 1 | Inverse of the last stage |

## Verification
The bench builds the block with the default `WIDTH` of 8. This keeps a full unload of a word, with the serial bits arriving behind it, down to ten edges, so the table can run the whole path from parallel word to serial tail. At this width it can also put inhibited edges between shifts and reload in the middle of a stream while the inhibit is high. The directed part drives the load level with no clock edge present, to show that the output is transparent, and tests load against reset.

// File: rtl/piso_pkg.sv
// Shared types for the parallel-load serial-out shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package piso_pkg;

    // What the stages do at the next rising edge when load is not active.
    typedef enum logic [1:0] {
        MODE_LOAD  = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_HOLD  = 2'd2,
        MODE_SHIFT = 2'd3
    } piso_mode_e;

endpackage

// File: rtl/piso_mode_decode.sv
// Turns the control inputs into per-edge stage commands.
// Priority: load, then clear, then inhibit, then shift.
// Assumes: the stages themselves also see load_n directly for the asynchronous path.
module piso_mode_decode
    import piso_pkg::*;
(
    input  logic load_n,
    input  logic rst_n,
    input  logic hold_clk,
    output logic clr,
    output logic hold
);

    piso_mode_e mode;

    // Resolve the control inputs by priority.
    always_comb begin
        if (!load_n)
            mode = MODE_LOAD;
        else if (!rst_n)
            mode = MODE_CLEAR;
        else if (hold_clk)
            mode = MODE_HOLD;
        else
            mode = MODE_SHIFT;
    end

    // Drive the stage commands from the resolved mode.
    always_comb begin
        clr  = (mode == MODE_CLEAR);
        hold = (mode == MODE_HOLD) || (mode == MODE_LOAD);
    end

endmodule

// File: rtl/piso_stage.sv
// One storage stage with asynchronous parallel load and synchronous clear, hold and shift.
// Assumes: par_bit is stable while load_n is low between clock edges;
// the stage recaptures it on every edge during load.
module piso_stage (
    input  logic clk,
    input  logic load_n,
    input  logic clr,
    input  logic hold,
    input  logic par_bit,
    input  logic shift_in,
    output logic q
);

    // Asynchronous load, otherwise clear, hold or shift on the rising edge.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            q <= par_bit;
        else if (clr)
            q <= 1'b0;
        else if (!hold)
            q <= shift_in;
    end

endmodule

// File: rtl/piso_out_tap.sv
// Drives the visible pin pair from the last stage.
// During load it passes the parallel MSB through, so the pin is level-transparent.
// Assumes: last_q already holds par_msb once load has settled.
module piso_out_tap (
    input  logic load_n,
    input  logic par_msb,
    input  logic last_q,
    output logic ser_out,
    output logic ser_out_n
);

    // Choose between the transparent load path and the stored last stage.
    always_comb begin
        ser_out   = load_n ? last_q : par_msb;
        ser_out_n = ~ser_out;
    end

endmodule

// File: rtl/piso_shifter.sv
// Parallel-load serial-out shift register of WIDTH stages.
// Only stage WIDTH-1 and its inverse leave the block (R1).
// Assumes: WIDTH >= 2; par_in is held stable while load_n is low.
module piso_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             hold_clk,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic             ser_out_n
);

    localparam int LAST = WIDTH - 1;

    logic             clr;
    logic             hold;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    piso_mode_decode u_decode (
        .load_n   (load_n),
        .rst_n    (rst_n),
        .hold_clk (hold_clk),
        .clr      (clr),
        .hold     (hold)
    );

    // Shift-chain wiring: serial input into stage 0, each stage feeds the next.
    always_comb begin
        stage_d = {stage_q[LAST-1:0], ser_in};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        piso_stage u_stage (
            .clk      (clk),
            .load_n   (load_n),
            .clr      (clr),
            .hold     (hold),
            .par_bit  (par_in[i]),
            .shift_in (stage_d[i]),
            .q        (stage_q[i])
        );
    end

    piso_out_tap u_tap (
        .load_n    (load_n),
        .par_msb   (par_in[LAST]),
        .last_q    (stage_q[LAST]),
        .ser_out   (ser_out),
        .ser_out_n (ser_out_n)
    );

endmodule

// File: rtl/piso_checker.sv
// Temporal checks for piso_shifter, attached with bind.
// Assumes: load_n changes at most once between two rising edges.
module piso_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             hold_clk,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stages,
    input logic             ser_out,
    input logic             ser_out_n
);

    // R4: an enabled edge moves the word up one place and takes ser_in.
    p_shift_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !hold_clk) ##1 load_n |->
            stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

    // R6: an inhibited edge keeps the visible stage.
    p_inhibit_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && hold_clk) ##1 load_n |-> $stable(ser_out));

    // R3: edges during load leave the stages equal to the parallel word.
    p_load_no_shift_r3: assert property (@(posedge clk)
        (!load_n) ##1 (!load_n) |-> stages == $past(par_in));

    // R8: a clear with load inactive empties every stage.
    p_clear_empties_r8: assert property (@(posedge clk)
        (load_n && !rst_n) ##1 load_n |-> stages == '0);

    // R7: the two output pins are always opposite.
    p_pins_opposite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_n != ser_out);

endmodule

bind piso_shifter piso_checker #(.WIDTH(WIDTH)) u_piso_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .hold_clk  (hold_clk),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .stages    (stage_q),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
);

// File: tb/piso_shifter_test.sv
// Bench for piso_shifter: a vector table walk, then directed reset and corner cases.
module piso_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int NVEC       = 15;

    // Vector fields: {load_n, hold_clk, ser_in, par_in[7:0], exp_ser_out, req[3:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'hB4, 1'b1, 4'd2},  // R2 load B4, MSB visible
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 shift 1 -> P6
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 shift 2 -> P5
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 4'd6},  // R6 inhibited
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 4'd6},  // R6 inhibited
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 4'd5},  // R5 shift 3 -> P4
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 shift 4 -> P3
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 shift 5 -> P2
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 shift 6 -> P1
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 shift 7 -> P0
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 shift 8 -> serial bit 1
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd4},  // R4 shift 9 -> serial bit 2
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 shift 10 -> serial bit 3
        {1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd9},  // R9 load under inhibit
        {1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 4'd1}   // R1 par ignored when shifting, P6 of 5A
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_n = 1'b1;
    logic             hold_clk = 1'b0;
    logic             ser_in = 1'b0;
    logic [WIDTH-1:0] par_in = '0;
    logic             ser_out;
    logic             ser_out_n;

    int n_checks = 0;
    int n_fails  = 0;

    piso_shifter #(.WIDTH(WIDTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .hold_clk  (hold_clk),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .ser_out   (ser_out),
        .ser_out_n (ser_out_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (ser_out !== exp || ser_out_n !== ~exp) begin
            n_fails++;
            $display("FAIL %s: ser_out=%b ser_out_n=%b expected %b/%b",
                     req, ser_out, ser_out_n, exp, ~exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected end before timeout");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R8: reset clears the stages.
        repeat (2) @(posedge clk);
        #1 check("R8 reset state", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at negedge, sample just after the rising edge.
        for (int v = 0; v < NVEC; v++) begin
            load_n   = VEC[v][15];
            hold_clk = VEC[v][14];
            ser_in   = VEC[v][13];
            par_in   = VEC[v][12:5];
            @(posedge clk);
            #1 check($sformatf("R%0d vector %0d", VEC[v][3:0], v), VEC[v][4]);
            @(negedge clk);
        end

        // R2: load without any clock edge, pin follows the parallel MSB.
        load_n = 1'b0;
        par_in = 8'h80;
        #1 check("R2 async load shows MSB", 1'b1);
        par_in = 8'h01;
        #1 check("R2 level transparency", 1'b0);
        // R3: an edge during load changes nothing.
        @(posedge clk);
        #1 check("R3 edge during load", 1'b0);
        @(negedge clk);

        // R1/R5: release, seven shifts reach P0 = 1, the eighth brings ser_in 0.
        load_n = 1'b1;
        ser_in = 1'b0;
        #1 check("R5 before first edge", 1'b0);
        repeat (7) @(posedge clk);
        #1 check("R1 P0 after seven edges", 1'b1);
        @(posedge clk);
        #1 check("R1 serial tail after eight edges", 1'b0);
        @(negedge clk);

        // R8: load wins over reset.
        rst_n  = 1'b0;
        load_n = 1'b0;
        par_in = 8'hFF;
        @(posedge clk);
        #1 check("R8 load beats reset", 1'b1);
        @(negedge clk);
        rst_n  = 1'b1;
        load_n = 1'b1;
        #1 check("R8 word kept after release", 1'b1);

        // R8: reset with load inactive clears a loaded word.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check("R8 clear with load inactive", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: complement checked on every sample above; one more explicit check.
        #1 check("R7 complement after clear", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule